// File: doc/BRIEF.md
# Sync-Header Error-Rate Monitor

This block watches the 2-bit synchronization header on each received 66-bit block of a 10 Gb/s serial link. It starts only after the upstream aligner reports that block lock is established. For every block it decides whether the header is legal. It counts the illegal ones over back-to-back windows of fixed length, where the nominal window is 125 microseconds. When one window holds more than sixteen illegal headers, the block raises a high-error-rate status flag.

The header arrives as a stream qualified by a valid strobe. The monitor only observes that stream. It can accept a header in every cycle and never applies back-pressure, so it has no ready output; a cycle with the strobe low carries no header and is ignored. The window length is a parameter counted in valid strobes. The default of 19531 matches 125 µs at a block rate of 156.25 MHz. Lock acquisition, payload decoding and descrambling belong to other blocks.

Top module: `hiber_monitor`

## Requirements
- R1: During and right after reset, `hi_ber_o` is 0 and both the window position and the illegal-header count are zero.
- R2: A header of 2'b01 or 2'b10 is legal and never adds to the count.
- R3: A header of 2'b00 or 2'b11 is illegal and adds one to the count when it arrives with `hdr_valid` high and `lock_in` high.
- R4: A window that contains exactly 16 illegal headers leaves `hi_ber_o` at 0.
- R5: The clock edge that samples the 17th illegal header of a window sets `hi_ber_o`, so the output reads 1 in the cycle after that strobe.
- R6: A window spans WIN_LEN valid strobes. On the edge that samples its last strobe, the count returns to zero and `hi_ber_o` takes the value "this window held more than 16 illegal headers". A clean window therefore clears the flag.
- R7: Cycles with `hdr_valid` low do not advance the window and do not count, whatever the value on `sync_hdr`.
- R8: While `lock_in` is 0, the window position and the count are held at zero and `hi_ber_o` keeps its last value. When lock returns, a fresh window begins.
- R9: The count saturates instead of wrapping. A window with any number of illegal headers above 16, including one where every header is illegal, ends with `hi_ber_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Strobe: a block header is present on `sync_hdr` |
| sync_hdr | input | 2 | Sync header of the current block |
| lock_in | input | 1 | Block lock indication from the aligner |
| hi_ber_o | output | 1 | High error-rate status |

## Verification
Several properties are checked on every cycle. The window position never passes its bound and stays still when no strobe arrives. Within a window the count never decreases. The flag never moves while lock is absent. Once a window's count passes the threshold, the flag is high on the next cycle, and a window that ends at or under the threshold leaves the flag low. Other behaviours only show up in the bench scenarios: the exact cycle the flag rises on the 17th illegal header, the boundary at 16, that illegal values on idle cycles are ignored, that saturation holds across a window made entirely of illegal headers, and that a window restarts cleanly after lock returns.

// File: rtl/hiber_pkg.sv
package hiber_pkg;

  typedef logic [1:0] sync_hdr_t;

  // legal header codes: one of the two bits set
  localparam sync_hdr_t HDR_DATA = 2'b01;
  localparam sync_hdr_t HDR_CTRL = 2'b10;

  function automatic logic hdr_is_bad(input sync_hdr_t h);
    return (h != HDR_DATA) && (h != HDR_CTRL);
  endfunction

endpackage

// File: rtl/hiber_hdr_classify.sv
module hiber_hdr_classify
  import hiber_pkg::*;
(
  input  logic      hdr_valid,
  input  logic      lock_in,
  input  sync_hdr_t sync_hdr,
  output logic      adv_o,
  output logic      bad_o
);

  // a strobe only counts toward the window while lock holds
  always_comb begin
    adv_o = hdr_valid && lock_in;
    bad_o = adv_o && hdr_is_bad(sync_hdr);
  end

endmodule

// File: rtl/hiber_window_timer.sv
module hiber_window_timer #(
  parameter int WIN_LEN = 19531
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic adv_i,
  output logic win_end_o
);

  localparam int TW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

  logic [TW-1:0] pos_q;

  assign win_end_o = adv_i && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_in) begin
      pos_q <= '0;
    end else if (adv_i) begin
      pos_q <= win_end_o ? '0 : pos_q + 1'b1;
    end
  end

  // R7
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_in && !adv_i) |=> $stable(pos_q));

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST);

endmodule

// File: rtl/hiber_err_counter.sv
module hiber_err_counter #(
  parameter int THRESH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_in,
  input  logic bad_i,
  input  logic win_end_i,
  output logic over_o
);

  localparam int CW = $clog2(THRESH + 2);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] LIM  = CW'(THRESH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;

  // saturating increment
  always_comb begin
    cnt_nx = cnt_q;
    if (bad_i && cnt_q != MAXV) cnt_nx = cnt_q + 1'b1;
    over_o = cnt_nx > LIM;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_in || win_end_i) cnt_q <= '0;
    else                                 cnt_q <= cnt_nx;
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_in && !win_end_i) |=> cnt_q >= $past(cnt_q));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> cnt_q == '0);

endmodule

// File: rtl/hiber_status_reg.sv
module hiber_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic win_end_i,
  input  logic over_i,
  output logic hi_ber_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_ber_o <= 1'b0;
    end else if (adv_i) begin
      if (win_end_i)   hi_ber_o <= over_i;
      else if (over_i) hi_ber_o <= 1'b1;
    end
  end

endmodule

// File: rtl/hiber_monitor.sv
module hiber_monitor
  import hiber_pkg::*;
#(
  parameter int WIN_LEN = 19531,
  parameter int THRESH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic [1:0] sync_hdr,
  input  logic       lock_in,
  output logic       hi_ber_o
);

  logic adv, bad, win_end, over;

  hiber_hdr_classify u_cls (
    .hdr_valid (hdr_valid),
    .lock_in   (lock_in),
    .sync_hdr  (sync_hdr_t'(sync_hdr)),
    .adv_o     (adv),
    .bad_o     (bad)
  );

  hiber_window_timer #(.WIN_LEN(WIN_LEN)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_in   (lock_in),
    .adv_i     (adv),
    .win_end_o (win_end)
  );

  hiber_err_counter #(.THRESH(THRESH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_in   (lock_in),
    .bad_i     (bad),
    .win_end_i (win_end),
    .over_o    (over)
  );

  hiber_status_reg u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_i     (adv),
    .win_end_i (win_end),
    .over_i    (over),
    .hi_ber_o  (hi_ber_o)
  );

  // R5
  rise_on_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && over) |=> hi_ber_o);

  // R6
  clean_window_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !over) |=> !hi_ber_o);

  // R8
  hold_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> $stable(hi_ber_o));

endmodule

// File: tb/test_hiber_monitor.sv
`timescale 1ns/1ps
module test_hiber_monitor;

  localparam int WIN = 64;
  localparam int THR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [1:0] sync_hdr = 2'b01;
  logic       lock_in = 1'b0;
  logic       hi_ber_o;

  always #10 clk = ~clk;

  hiber_monitor #(.WIN_LEN(WIN), .THRESH(THR)) i_hiber_monitor (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
    .sync_hdr(sync_hdr), .lock_in(lock_in), .hi_ber_o(hi_ber_o)
  );

  typedef struct { logic exp; string req; } item_t;
  item_t sb[$];
  int checks = 0;
  int errors = 0;

  // reference model state, derived from the requirements
  int  m_pos = 0;
  int  m_cnt = 0;
  logic m_hi = 1'b0;

  task automatic send(input logic v, input logic [1:0] h, input logic lk,
                      input string rq);
    item_t it;
    @(negedge clk);
    hdr_valid = v; sync_hdr = h; lock_in = lk;
    if (!lk) begin
      m_pos = 0; m_cnt = 0;
    end else if (v) begin
      if (h == 2'b00 || h == 2'b11) m_cnt++;
      if (m_pos == WIN - 1) begin
        m_hi = (m_cnt > THR); m_cnt = 0; m_pos = 0;
      end else begin
        m_pos++;
        if (m_cnt > THR) m_hi = 1'b1;
      end
    end
    it.exp = m_hi; it.req = rq;
    sb.push_back(it);
  endtask

  // monitor: compares the flag after the edge that sampled each item
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (hi_ber_o !== it.exp) begin
        errors++;
        $display("FAIL %s: hi_ber_o=%b expected %b at %0t",
                 it.req, hi_ber_o, it.exp, $time);
      end
    end
  end

  task automatic window_with_bad(input int nbad, input string rq);
    for (int i = 0; i < WIN; i++)
      send(1'b1, (i < nbad) ? ((i % 2) ? 2'b11 : 2'b00)
                            : ((i % 2) ? 2'b10 : 2'b01), 1'b1, rq);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset value
    if (hi_ber_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: hi_ber_o=%b expected 0", hi_ber_o);
    end
    @(negedge clk); rst_n = 1'b1;
    send(1'b0, 2'b00, 1'b0, "R1");
    window_with_bad(0, "R2");              // all legal
    window_with_bad(16, "R4");             // boundary, R3 codes
    window_with_bad(17, "R5");             // rises on 17th
    window_with_bad(0, "R6");              // clean window clears
    // R7: idle cycles carrying illegal codes, gaps inside window
    for (int i = 0; i < WIN; i++) begin
      send(1'b1, (i < 10) ? 2'b00 : 2'b01, 1'b1, "R7");
      send(1'b0, 2'b11, 1'b1, "R7");
    end
    window_with_bad(WIN, "R9");            // every header illegal
    window_with_bad(0, "R6");
    // R8: lock loss while flag high, then fresh window
    window_with_bad(20, "R3");
    for (int i = 0; i < 5; i++) send(1'b1, 2'b00, 1'b0, "R8");
    for (int i = 0; i < 5; i++) send(1'b1, 2'b01, 1'b1, "R8");
    for (int i = 0; i < 5; i++) send(1'b1, 2'b11, 1'b0, "R8");
    window_with_bad(0, "R8");
    window_with_bad(0, "R6");
    window_with_bad(17, "R5");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule